// File: doc/BRIEF.md
# Segmented Task Memory Protection Unit

This unit sits between a small multitasking core and its word-addressed memory. It checks and translates each address the core issues. Physical memory is cut into a fixed number of equal segments. Segment 0 is owned by the supervisor, and every other segment holds exactly one user task. A privileged task-identity register selects which segment user code lives in. In user mode the core's address is treated as an offset inside that segment. Any attempt to reach outside the segment, or into the supervisor segment, is refused. In supervisor mode the full physical address is passed through unchanged.

The unit also models a per-segment stack that starts at the highest offset and grows toward offset 0. It supports push and pop requests, and it traps both overflow and underflow. Every illegal request produces a one-cycle fault pulse. The pulse carries a fault kind and the offending address. A faulting request leaves memory and internal state untouched. All outputs are registered and appear one clock after the request. Only one request is taken per cycle, with a fixed priority: task-register write, then push, then pop, then plain access.

Top module: `seg_guard`

## Requirements
- R1: After reset, the unit drives no memory enable, no fault, a task identity of 0, and a stack offset of all ones.
- R2: In supervisor mode, an access drives mem_en one cycle later, with mem_addr equal to acc_addr and mem_we equal to acc_write.
- R3: In user mode with a nonzero task identity, an access whose bits above the offset field are all zero drives mem_addr = {task identity, acc_addr[OFF_BITS-1:0]}.
- R4: In user mode, an access with any nonzero bit above the offset field raises a segment fault (fault_kind 0) with fault_addr = acc_addr, and it drives no memory enable.
- R5: In user mode with task identity 0, every access, push and pop raises a segment fault (fault_kind 0), so the supervisor segment cannot be reached.
- R6: A task-register write in supervisor mode loads tid_wdata into cur_tid on the next cycle, resets the stack offset to all ones, and drives no memory enable.
- R7: A task-register write in user mode, of any value including 0, raises a privilege fault (fault_kind 1) with fault_addr = zero-extended tid_wdata, and it leaves cur_tid unchanged.
- R8: A push writes at {segment, offset}, where the segment is cur_tid in user mode and 0 in supervisor mode. The offset then decrements by one.
- R9: A push while the stack offset is 0 raises a stack-overflow fault (fault_kind 2) with fault_addr = 0. It performs no write and leaves the offset at 0.
- R10: A pop first increments the offset and then reads at {segment, new offset}. A pop while the offset is all ones raises an underflow fault (fault_kind 3) with fault_addr = that offset, and it performs no read.
- R11: A fault is high for exactly the cycle that follows the faulting request. mem_en is never high in the same cycle as fault.
- R12: When several requests arrive in one cycle, only the one with the highest priority takes effect. The order is task write, then push, then pop, then access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sup_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| tid_we | input | 1 | Request to write the task-identity register |
| tid_wdata | input | SEG_BITS | Value for the task-identity register |
| stk_push | input | 1 | Stack push request |
| stk_pop | input | 1 | Stack pop request |
| acc_valid | input | 1 | Plain memory access request |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | SEG_BITS+OFF_BITS | Address from the core (logical in user mode, physical in supervisor mode) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | SEG_BITS+OFF_BITS | Physical word address |
| cur_tid | output | SEG_BITS | Current task identity |
| fault | output | 1 | One-cycle fault pulse |
| fault_kind | output | 2 | 0 segment, 1 privilege, 2 stack overflow, 3 stack underflow |
| fault_addr | output | SEG_BITS+OFF_BITS | Address or value that caused the fault |

## Verification
The bench builds the unit with SEG_BITS=4 and OFF_BITS=6. These values keep sixteen segments but make each one only 64 words deep. With them, a full stack can be filled with 63 pushes and driven into overflow within a short run. Four address bits still sit above the offset field, so out-of-segment user addresses can be produced, and every task identity, including the reserved 0, can be tried. Because the width relations stay the same at the default values, the same translation and fault paths are covered there too.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  typedef enum logic [1:0] {
    FLT_SEG  = 2'd0,
    FLT_PRIV = 2'd1,
    FLT_OVF  = 2'd2,
    FLT_UNF  = 2'd3
  } flt_e;

endpackage

// File: rtl/seg_guard_xlate.sv
module seg_guard_xlate #(
  parameter int SEG_BITS = 4,
  parameter int OFF_BITS = 10,
  localparam int PA_W = SEG_BITS + OFF_BITS
) (
  input  logic                sup,
  input  logic [SEG_BITS-1:0] tid,
  input  logic [PA_W-1:0]     laddr,
  output logic [PA_W-1:0]     paddr,
  output logic                seg_err
);

  logic hi_set;
  logic tid_zero;

  assign hi_set   = |laddr[PA_W-1:OFF_BITS];
  assign tid_zero = (tid == '0);

  always_comb begin
    if (sup) begin
      paddr   = laddr;
      seg_err = 1'b0;
    end else begin
      paddr   = {tid, laddr[OFF_BITS-1:0]};
      seg_err = hi_set || tid_zero;
    end
  end

endmodule

// File: rtl/seg_guard_stack.sv
module seg_guard_stack #(
  parameter int OFF_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                reload,
  input  logic                dec,
  input  logic                inc,
  output logic [OFF_BITS-1:0] sp,
  output logic [OFF_BITS-1:0] sp_up,
  output logic                at_floor,
  output logic                at_ceil
);

  logic [OFF_BITS-1:0] sp_q, sp_d;
  logic                sp_en;

  assign sp       = sp_q;
  assign sp_up    = sp_q + 1'b1;
  assign at_floor = (sp_q == '0);
  assign at_ceil  = (sp_q == '1);
  assign sp_en    = reload | dec | inc;

  always_comb begin
    sp_d = sp_q;
    if (reload)   sp_d = '1;
    else if (dec) sp_d = sp_q - 1'b1;
    else if (inc) sp_d = sp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= '1;
    else if (sp_en) sp_q <= sp_d;
  end

  assert_push_floor_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    dec |-> !at_floor);

  assert_pop_ceil_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    inc |-> !at_ceil);

  assert_push_step_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec && !reload) |=> sp_q == OFF_BITS'($past(sp_q) - 1'b1));

endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int SEG_BITS = 4,
  parameter int OFF_BITS = 10,
  localparam int PA_W = SEG_BITS + OFF_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sup_mode,
  input  logic                tid_we,
  input  logic [SEG_BITS-1:0] tid_wdata,
  input  logic                stk_push,
  input  logic                stk_pop,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [PA_W-1:0]     acc_addr,
  output logic                mem_en,
  output logic                mem_we,
  output logic [PA_W-1:0]     mem_addr,
  output logic [SEG_BITS-1:0] cur_tid,
  output logic                fault,
  output logic [1:0]          fault_kind,
  output logic [PA_W-1:0]     fault_addr
);

  // reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  // request decode, fixed priority
  logic do_tid, do_push, do_pop, do_acc;
  assign do_tid  = tid_we;
  assign do_push = !tid_we && stk_push;
  assign do_pop  = !tid_we && !stk_push && stk_pop;
  assign do_acc  = !tid_we && !stk_push && !stk_pop && acc_valid;

  logic [SEG_BITS-1:0] tid_q;
  logic [OFF_BITS-1:0] sp, sp_up;
  logic                at_floor, at_ceil;
  logic                reload, dec, inc, tid_ld;

  seg_guard_stack #(.OFF_BITS(OFF_BITS)) u_stack (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .reload   (reload),
    .dec      (dec),
    .inc      (inc),
    .sp       (sp),
    .sp_up    (sp_up),
    .at_floor (at_floor),
    .at_ceil  (at_ceil)
  );

  logic [PA_W-1:0] x_laddr, x_paddr, sp_ext;
  logic            x_err;

  assign sp_ext  = {{SEG_BITS{1'b0}}, sp};
  assign x_laddr = do_push ? sp_ext :
                   do_pop  ? {{SEG_BITS{1'b0}}, sp_up} : acc_addr;

  seg_guard_xlate #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS)) u_xlate (
    .sup     (sup_mode),
    .tid     (tid_q),
    .laddr   (x_laddr),
    .paddr   (x_paddr),
    .seg_err (x_err)
  );

  // next-state
  logic            en_d, we_d, flt_d;
  logic [PA_W-1:0] addr_d, faddr_d;
  flt_e            kind_d;

  always_comb begin
    en_d    = 1'b0;
    we_d    = 1'b0;
    addr_d  = '0;
    flt_d   = 1'b0;
    kind_d  = FLT_SEG;
    faddr_d = '0;
    tid_ld  = 1'b0;
    reload  = 1'b0;
    dec     = 1'b0;
    inc     = 1'b0;
    if (do_tid) begin
      if (sup_mode) begin
        tid_ld = 1'b1;
        reload = 1'b1;
      end else begin
        flt_d   = 1'b1;
        kind_d  = FLT_PRIV;
        faddr_d = {{OFF_BITS{1'b0}}, tid_wdata};
      end
    end else if (do_push) begin
      if (x_err) begin
        flt_d   = 1'b1;
        faddr_d = sp_ext;
      end else if (at_floor) begin
        flt_d   = 1'b1;
        kind_d  = FLT_OVF;
        faddr_d = sp_ext;
      end else begin
        en_d   = 1'b1;
        we_d   = 1'b1;
        addr_d = x_paddr;
        dec    = 1'b1;
      end
    end else if (do_pop) begin
      if (x_err) begin
        flt_d   = 1'b1;
        faddr_d = sp_ext;
      end else if (at_ceil) begin
        flt_d   = 1'b1;
        kind_d  = FLT_UNF;
        faddr_d = sp_ext;
      end else begin
        en_d   = 1'b1;
        addr_d = x_paddr;
        inc    = 1'b1;
      end
    end else if (do_acc) begin
      if (x_err) begin
        flt_d   = 1'b1;
        faddr_d = acc_addr;
      end else begin
        en_d   = 1'b1;
        we_d   = acc_write;
        addr_d = x_paddr;
      end
    end
  end

  // registers
  logic            en_q, we_q, flt_q;
  logic [PA_W-1:0] addr_q, faddr_q;
  flt_e            kind_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tid_q <= '0;
    end else if (tid_ld) begin
      tid_q <= tid_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      flt_q   <= 1'b0;
      kind_q  <= FLT_SEG;
      faddr_q <= '0;
    end else begin
      en_q    <= en_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      flt_q   <= flt_d;
      kind_q  <= kind_d;
      faddr_q <= faddr_d;
    end
  end

  assign mem_en     = en_q;
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign cur_tid    = tid_q;
  assign fault      = flt_q;
  assign fault_kind = kind_q;
  assign fault_addr = faddr_q;

  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    fault |-> !mem_en);

  assert_priv_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (tid_we && !sup_mode) |=> $stable(tid_q));

  assert_super_pass_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (do_acc && sup_mode) |=> (mem_en && mem_addr == $past(acc_addr)));

  assert_user_map_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (do_acc && !sup_mode && tid_q != '0 && acc_addr[PA_W-1:OFF_BITS] == '0)
      |=> (mem_en && mem_addr == {$past(tid_q), $past(acc_addr[OFF_BITS-1:0])}));

  assert_out_of_seg_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (do_acc && !sup_mode && acc_addr[PA_W-1:OFF_BITS] != '0)
      |=> (fault && fault_kind == FLT_SEG && !mem_en));

  assert_seg0_hidden_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!sup_mode && tid_q == '0 && !tid_we && (stk_push || stk_pop || acc_valid))
      |=> (fault && !mem_en));

endmodule

// File: tb/seg_guard_test.sv
`timescale 1ns/1ps
module seg_guard_test;

  localparam int SB = 4;
  localparam int OB = 6;
  localparam int LW = SB + OB;
  localparam logic [OB-1:0] SP_TOP = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sup_mode = 1'b0, tid_we = 1'b0, stk_push = 1'b0, stk_pop = 1'b0;
  logic          acc_valid = 1'b0, acc_write = 1'b0;
  logic [SB-1:0] tid_wdata = '0;
  logic [LW-1:0] acc_addr = '0;
  logic          mem_en, mem_we, fault;
  logic [LW-1:0] mem_addr, fault_addr;
  logic [SB-1:0] cur_tid;
  logic [1:0]    fault_kind;

  always #10 clk = ~clk;

  seg_guard #(.SEG_BITS(SB), .OFF_BITS(OB)) uut (
    .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .tid_we(tid_we),
    .tid_wdata(tid_wdata), .stk_push(stk_push), .stk_pop(stk_pop),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .cur_tid(cur_tid),
    .fault(fault), .fault_kind(fault_kind), .fault_addr(fault_addr)
  );

  typedef struct {
    int            due;
    logic          en, we, flt;
    logic [LW-1:0] addr, faddr;
    logic [1:0]    kind;
    logic [SB-1:0] tid;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  logic [SB-1:0] tid_m = '0;
  logic [OB-1:0] sp_m = SP_TOP;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic ok;
      e = q.pop_front();
      ok = (mem_en === e.en) && (fault === e.flt) && (cur_tid === e.tid);
      if (e.en)  ok = ok && (mem_we === e.we) && (mem_addr === e.addr);
      if (e.flt) ok = ok && (fault_kind === e.kind) && (fault_addr === e.faddr);
      n_checks++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: got en=%b we=%b addr=%h flt=%b kind=%0d faddr=%h tid=%0d, exp en=%b we=%b addr=%h flt=%b kind=%0d faddr=%h tid=%0d",
          e.tag, mem_en, mem_we, mem_addr, fault, fault_kind, fault_addr, cur_tid,
          e.en, e.we, e.addr, e.flt, e.kind, e.faddr, e.tid);
      end
    end
  end

  // driver: one request per cycle, expectation pushed alongside
  task automatic step(input logic sup, input logic tw, input logic [SB-1:0] twd,
                      input logic ps, input logic pp, input logic av,
                      input logic aw, input logic [LW-1:0] aa, input string tag);
    exp_t e;
    logic [SB-1:0] seg;
    @(negedge clk);
    sup_mode = sup; tid_we = tw; tid_wdata = twd; stk_push = ps; stk_pop = pp;
    acc_valid = av; acc_write = aw; acc_addr = aa;
    e.due = cyc + 1; e.tag = tag;
    e.en = 0; e.we = 0; e.flt = 0; e.addr = '0; e.faddr = '0; e.kind = 2'd0;
    seg = sup ? '0 : tid_m;
    if (tw) begin
      if (sup) begin tid_m = twd; sp_m = SP_TOP; end
      else begin e.flt = 1; e.kind = 2'd1; e.faddr = LW'(twd); end
    end else if (ps) begin
      if (!sup && tid_m == '0) begin e.flt = 1; e.kind = 2'd0; e.faddr = LW'(sp_m); end
      else if (sp_m == '0) begin e.flt = 1; e.kind = 2'd2; e.faddr = '0; end
      else begin e.en = 1; e.we = 1; e.addr = {seg, sp_m}; sp_m = sp_m - 1'b1; end
    end else if (pp) begin
      if (!sup && tid_m == '0) begin e.flt = 1; e.kind = 2'd0; e.faddr = LW'(sp_m); end
      else if (sp_m == SP_TOP) begin e.flt = 1; e.kind = 2'd3; e.faddr = LW'(sp_m); end
      else begin sp_m = sp_m + 1'b1; e.en = 1; e.addr = {seg, sp_m}; end
    end else if (av) begin
      if (sup) begin e.en = 1; e.we = aw; e.addr = aa; end
      else if ((aa >> OB) != 0 || tid_m == '0) begin e.flt = 1; e.kind = 2'd0; e.faddr = aa; end
      else begin e.en = 1; e.we = aw; e.addr = {tid_m, aa[OB-1:0]}; end
    end
    e.tid = tid_m;
    q.push_back(e);
  endtask

  task automatic acc(input logic sup, input logic w, input logic [LW-1:0] a, input string tag);
    step(sup, 0, '0, 0, 0, 1, w, a, tag);
  endtask
  task automatic settid(input logic sup, input logic [SB-1:0] v, input string tag);
    step(sup, 1, v, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic push(input logic sup, input string tag);
    step(sup, 0, '0, 1, 0, 0, 0, '0, tag);
  endtask
  task automatic pop(input logic sup, input string tag);
    step(sup, 0, '0, 0, 1, 0, 0, '0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, '0, 0, 0, 0, 0, '0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_checks++;
    if (mem_en !== 0 || fault !== 0 || cur_tid !== '0) begin
      n_fail++;
      $display("FAIL R1: got en=%b flt=%b tid=%0d, exp 0 0 0", mem_en, fault, cur_tid);
    end

    acc(1, 1, 10'h3A5, "R2 supervisor write passthrough");
    acc(1, 0, 10'h012, "R2 supervisor read passthrough");
    acc(0, 0, 10'h005, "R5 user access with task 0");
    push(0, "R5 user push with task 0");
    pop(0, "R5 user pop with task 0");
    settid(1, 4'd5, "R6 supervisor task write");
    acc(0, 0, 10'h02B, "R3 user read mapping");
    acc(0, 1, 10'h03F, "R3 user write top offset");
    acc(0, 1, 10'h040, "R4 bit above offset");
    idle("R11 fault clears after one cycle");
    acc(0, 0, 10'h3FF, "R4 all high bits");
    settid(0, 4'd7, "R7 user task write");
    settid(0, 4'd0, "R7 user write of zero");
    acc(0, 0, 10'h001, "R7 task unchanged after user write");
    pop(0, "R10 underflow at top");
    push(0, "R8 push one");
    push(0, "R8 push two");
    push(0, "R8 push three");
    pop(0, "R10 pop after pushes");
    push(1, "R8 supervisor push uses segment 0");
    step(1, 1, 4'd9, 1, 1, 1, 1, 10'h111, "R12 task write wins");
    step(0, 0, '0, 1, 1, 1, 0, 10'h222, "R12 push wins");
    step(0, 0, '0, 0, 1, 1, 1, 10'h033, "R12 pop wins");
    settid(1, 4'd12, "R6 reload stack");
    for (int i = 0; i < 63; i++) push(0, "R8 fill stack");
    push(0, "R9 overflow at offset 0");
    push(0, "R9 overflow repeats, no write");
    pop(0, "R10 pop after overflow");
    acc(1, 0, 10'h000, "R2 supervisor reaches segment 0");
    idle("R11 idle");
    idle("R11 idle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule